// File: doc/BRIEF.md
# PWM Fault Trip Output Override

This block sits between a multi-channel PWM generator and the output pads. It watches four external fault lines, each with its own enable. When any enabled line asserts, the block latches a trip. While the trip is latched, every PWM channel marked active has its true and complementary pads forced to a programmed safe state. The safe state is a fixed high or low level, chosen separately for the true and complementary groups, or high impedance for both groups through one shared control.

The trip is sticky. A fault line that drops, or glitches, after the trip does not release the outputs. Only software can release them, by writing zero to the status bit, and it can do so after it has checked the state of the load. Software uses a single 8-bit register for the configuration and the status. An interrupt request follows the status bit.

Top module: `pwm_trip_guard`

## Requirements
- R1: After reset the status bit and `irq` are 0. Every pad follows its PWM input with its active-low output enable driven 0, and `reg_rdata` reads 0.
- R2: The register layout is fixed. Bits [3:0] enable fault lines 3..0. Bit 4 is the forced level of the true pads, bit 5 is the forced level of the complementary pads, bit 6 selects tristate, and bit 7 is the trip status. A trip is set when the bitwise AND of the enables with the synchronized fault lines is nonzero. A fault on a disabled line never sets it.
- R3: Each fault line passes through two synchronizing flops. A change on a fault line, sampled at a rising edge, shows in the status after the third rising edge and not earlier.
- R4: The trip stays set when the fault lines deassert. A register write with bit 7 at 0 clears it. A write with bit 7 at 1 neither sets nor clears it.
- R5: When a clearing write coincides with a cycle in which an enabled synchronized fault is asserted, the trip stays set.
- R6: While tripped with bit 6 at 0, the true pad of each active channel drives bit 4 and the complementary pad drives bit 5, with both output enables at 0.
- R7: While tripped with bit 6 at 1, both pads of each active channel drive data 0 with their active-low output enables at 1.
- R8: Channels whose `ch_en` bit is 0 pass their PWM inputs through with enables at 0, even while tripped.
- R9: `irq` equals the trip status bit in every cycle.
- R10: A register write stores bits [6:0], and they read back unchanged on `reg_rdata[6:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_p | input | N_CH | True PWM waveforms from the generator |
| pwm_n | input | N_CH | Complementary PWM waveforms |
| ch_en | input | N_CH | Per-channel active flags; only active channels are overridden |
| flt_in | input | N_FLT | Asynchronous active-high fault lines |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | N_FLT+4 | Register write data |
| reg_rdata | output | N_FLT+4 | Register read data, status in the top bit |
| irq | output | 1 | Interrupt request, level, follows the trip status |
| pad_p | output | N_CH | True pad data |
| pad_n | output | N_CH | Complementary pad data |
| pad_p_oen | output | N_CH | Active-low output enables for the true pads |
| pad_n_oen | output | N_CH | Active-low output enables for the complementary pads |

## Verification
The assertions assume that a write strobe lasts one cycle and that its data is valid in that cycle. They also assume that the fault lines settle before any clock edge. Beyond that they ask nothing of the lines, since the synchronizer makes their relation to the clock irrelevant.

The bench changes the fault lines, the strobe and the data only on the falling edge. It holds the fault lines quiet for three cycles before each clearing write, except where it aims at the set-over-clear case on purpose. It sweeps every combination of enable and fault pattern, and for the output override it sweeps every level and tristate setting against every channel mask and PWM pattern.

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard #(
  parameter int N_CH  = 4,
  parameter int N_FLT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   pwm_p,
  input  logic [N_CH-1:0]   pwm_n,
  input  logic [N_CH-1:0]   ch_en,
  input  logic [N_FLT-1:0]  flt_in,
  input  logic              reg_wr,
  input  logic [N_FLT+3:0]  reg_wdata,
  output logic [N_FLT+3:0]  reg_rdata,
  output logic              irq,
  output logic [N_CH-1:0]   pad_p,
  output logic [N_CH-1:0]   pad_n,
  output logic [N_CH-1:0]   pad_p_oen,
  output logic [N_CH-1:0]   pad_n_oen
);
  localparam int LVP = N_FLT;
  localparam int LVN = N_FLT + 1;
  localparam int TRI = N_FLT + 2;
  localparam int STS = N_FLT + 3;

  logic [N_FLT-1:0] sync1, sync2, flt_en;
  logic lvl_p, lvl_n, tri_q, trip_q;

  wire hit = |(sync2 & flt_en);
  wire clr = reg_wr && !reg_wdata[STS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      flt_en <= '0;
      lvl_p  <= 1'b0;
      lvl_n  <= 1'b0;
      tri_q  <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      sync1 <= flt_in;
      sync2 <= sync1;
      if (reg_wr) begin
        flt_en <= reg_wdata[N_FLT-1:0];
        lvl_p  <= reg_wdata[LVP];
        lvl_n  <= reg_wdata[LVN];
        tri_q  <= reg_wdata[TRI];
      end
      if (hit)      trip_q <= 1'b1;
      else if (clr) trip_q <= 1'b0;
    end
  end

  assign reg_rdata = {trip_q, tri_q, lvl_n, lvl_p, flt_en};
  assign irq       = trip_q;

  wire [N_CH-1:0] frc = {N_CH{trip_q}} & ch_en;

  assign pad_p     = (pwm_p & ~frc) | (frc & {N_CH{lvl_p & ~tri_q}});
  assign pad_n     = (pwm_n & ~frc) | (frc & {N_CH{lvl_n & ~tri_q}});
  assign pad_p_oen = frc & {N_CH{tri_q}};
  assign pad_n_oen = frc & {N_CH{tri_q}};

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> reg_rdata[STS]);

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[STS] && !(reg_wr && !reg_wdata[STS])) |=> reg_rdata[STS]);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !reg_rdata[STS]);

  assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hit));

  assert_tristate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[STS] && reg_rdata[TRI]) |-> ((pad_p_oen & ch_en) == ch_en && (pad_p & ch_en) == '0));

  assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_p ^ pwm_p) & ~ch_en) == '0 && (pad_n_oen & ~ch_en) == '0);
endmodule

// File: tb/test_pwm_trip_guard.sv
module test_pwm_trip_guard;
  localparam int N_CH = 4;
  localparam int N_FLT = 4;

  logic clk = 0, rst_n = 0;
  logic [N_CH-1:0] pwm_p = '0, pwm_n = '0, ch_en = '0;
  logic [N_FLT-1:0] flt_in = '0;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq;
  logic [N_CH-1:0] pad_p, pad_n, pad_p_oen, pad_n_oen;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pwm_trip_guard #(.N_CH(N_CH), .N_FLT(N_FLT)) i_pwm_trip_guard (
    .clk(clk), .rst_n(rst_n), .pwm_p(pwm_p), .pwm_n(pwm_n), .ch_en(ch_en),
    .flt_in(flt_in), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .pad_p(pad_p), .pad_n(pad_n), .pad_p_oen(pad_p_oen), .pad_n_oen(pad_n_oen));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic exp_t;
    logic [N_CH-1:0] ep, en, eo;
    pwm_p = 4'b1010; pwm_n = 4'b0101; ch_en = 4'hF;
    idle(3);
    chk("R1 status", reg_rdata, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 pad_p", pad_p, 4'b1010);
    chk("R1 pad_n", pad_n, 4'b0101);
    chk("R1 oen", {pad_p_oen, pad_n_oen}, 0);
    rst_n = 1;
    idle(2);

    wr(8'h5A);
    chk("R10 readback", reg_rdata, 8'h5A);
    wr(8'h25);
    chk("R10 readback", reg_rdata, 8'h25);

    for (int e = 0; e < 16; e++) begin
      for (int f = 0; f < 16; f++) begin
        flt_in = '0;
        idle(3);
        wr(8'(e));
        chk("R4 cleared", reg_rdata[7], 0);
        flt_in = 4'(f);
        idle(2);
        chk("R3 not before third edge", reg_rdata[7], 0);
        idle(1);
        exp_t = |(4'(e) & 4'(f));
        chk("R2 trip", reg_rdata[7], exp_t);
        chk("R9 irq", irq, exp_t);
        flt_in = '0;
        idle(4);
        chk("R4 sticky", reg_rdata[7], exp_t);
      end
    end

    flt_in = '0;
    idle(3);
    wr(8'h01);
    chk("R4 cleared", reg_rdata[7], 0);
    wr(8'h81);
    chk("R4 write one no set", reg_rdata[7], 0);
    flt_in = 4'h1;
    idle(3);
    chk("R4 set", reg_rdata[7], 1);
    wr(8'h81);
    flt_in = '0;
    idle(3);
    chk("R4 write one no clear", reg_rdata[7], 1);
    flt_in = 4'h1;
    idle(3);
    wr(8'h01);
    chk("R5 set beats clear", reg_rdata[7], 1);
    flt_in = '0;
    idle(3);
    wr(8'h01);
    chk("R4 clear after fault gone", reg_rdata[7], 0);

    flt_in = 4'h1;
    idle(3);
    for (int c = 0; c < 8; c++) begin
      wr(8'((c << 4) | 1));
      chk("R5 trip kept", reg_rdata[7], 1);
      for (int m = 0; m < 16; m++) begin
        for (int pw = 0; pw < 16; pw++) begin
          ch_en = 4'(m); pwm_p = 4'(pw); pwm_n = ~4'(pw);
          #1;
          for (int i = 0; i < N_CH; i++) begin
            if (m[i]) begin
              ep[i] = (c[2]) ? 1'b0 : c[0];
              en[i] = (c[2]) ? 1'b0 : c[1];
              eo[i] = c[2];
            end else begin
              ep[i] = pw[i]; en[i] = ~pw[i]; eo[i] = 1'b0;
            end
          end
          chk(c[2] ? "R7 pad_p" : "R6 pad_p", pad_p, ep);
          chk(c[2] ? "R7 pad_n" : "R6 pad_n", pad_n, en);
          chk(c[2] ? "R7 oen_p" : "R8 oen_p", pad_p_oen, eo);
          chk(c[2] ? "R7 oen_n" : "R8 oen_n", pad_n_oen, eo);
        end
      end
    end

    flt_in = '0;
    idle(3);
    wr(8'h71);
    chk("R4 released", reg_rdata[7], 0);
    ch_en = 4'hF; pwm_p = 4'b0110; pwm_n = 4'b1001;
    #1;
    chk("R8 pass when released", pad_p, 4'b0110);
    chk("R8 pass when released", pad_n, 4'b1001);
    chk("R8 oen when released", {pad_p_oen, pad_n_oen}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule